// File: doc/BRIEF.md
# UART Transmit-Empty Interrupt Generator

This block decides when a UART with a 16-entry transmit FIFO should raise its "transmitter ready for more data" interrupt. It watches the occupancy of the transmit FIFO and the host's writes into it. It then raises a pending flag when the FIFO drains. Two enable bits gate that flag: the FIFO-mode enable and the transmit interrupt enable.

The flag is raised at once when the FIFO had two or more bytes queued together since the last empty event. The flag is also raised at once for the first event after the FIFO-mode enable changes. In every other case the flag waits for a programmable stretch of bit ticks. That stretch is one full character frame minus its final stop bit, so a host that feeds one byte at a time is not interrupted before the shifter has nearly finished.

The block also merges the transmit flag with four external request inputs into a prioritised identification code. The host reads that code to find the source. Reading the code while it reports the transmit source clears the flag, and so does any write into the FIFO.

Top module: `uart_thre_irq`

## Requirements
- R1: `tx_empty_irq` is 1 only while both `fifo_on` and `tx_irq_en` are 1. A latched event that is masked by either bit reappears when both bits are set again.
- R2: The flag rises one clock after `tx_level` becomes 0, provided `tx_level` was 2 or more at some clock since the previous empty event.
- R3: In the other case, the flag rises on the N-th `bit_tick` after `tx_level` becomes 0. N = data bits + parity bit + stop bits. Data bits are `char_bits`+5 (00=5 … 11=8), the parity bit counts 1 when `parity_on` is set, and the stop bits number 2 when `two_stop` is set and 1 otherwise.
- R4: A pending delay is abandoned if a byte enters the FIFO before it expires. No flag results from that delay.
- R5: After `fifo_on` changes, the first event is immediate. Two clocks after the change, with the FIFO empty and both enables set, the flag is 1.
- R6: A `tx_push` clears the flag; it reads 0 on the next clock.
- R7: An `id_read` clears the flag only while `irq_id` reports 4'h2. A read while a higher source is reported leaves the flag set.
- R8: After a clear by `id_read`, the next transition of the FIFO into empty raises the flag again.
- R9: `irq_id` follows this priority order, highest first: line status 4'h6, then received data 4'h4 or character timeout 4'hC (data is reported when both are set), then transmit empty 4'h2, then modem status 4'h0.
- R10: With no source active, `irq_id` is 4'h1 and `irq_any` is 0. `irq_any` is the inverse of `irq_id` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_on | input | 1 | FIFO-mode enable bit |
| tx_irq_en | input | 1 | Transmit interrupt enable bit |
| tx_level | input | 5 | Transmit FIFO occupancy, 0..16 |
| tx_push | input | 1 | Host write into the transmit FIFO |
| id_read | input | 1 | Host read of the identification code |
| bit_tick | input | 1 | One pulse per serial bit time |
| char_bits | input | 2 | Data bits minus 5 |
| parity_on | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| src_line | input | 1 | Receiver line-status request |
| src_rxdata | input | 1 | Received-data request |
| src_rxtimeout | input | 1 | Character-timeout request |
| src_modem | input | 1 | Modem-status request |
| tx_empty_irq | output | 1 | Gated transmit-empty pending flag |
| irq_id | output | 4 | Prioritised identification code |
| irq_any | output | 1 | Any interrupt pending |

## Verification
The hardest case to reach is a delayed event that is cancelled part-way. Reaching it needs a FIFO that drained from a single byte, a few bit ticks, and then a new byte before the count runs out. The bench reaches it by driving the level from 1 to 0, issuing three ticks, and pushing a byte. It then runs a dozen more ticks to show that no flag appears. A second drain with a different frame format shows the count starts over at the new length.

// File: rtl/uart_thre_irq.sv
module uart_thre_irq #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic             tx_irq_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_push,
  input  logic             id_read,
  input  logic             bit_tick,
  input  logic [1:0]       char_bits,
  input  logic             parity_on,
  input  logic             two_stop,
  input  logic             src_line,
  input  logic             src_rxdata,
  input  logic             src_rxtimeout,
  input  logic             src_modem,
  output logic             tx_empty_irq,
  output logic [3:0]       irq_id,
  output logic             irq_any
);

  logic             pend, empty_q, pair_seen, first_free, fifo_on_q;
  logic [DLY_W-1:0] dly;

  logic is_empty, went_empty, enabled, fire_free, fire_now, fire_late;
  logic cancel, clr, tx_reported;
  logic [DLY_W-1:0] frame_len;

  assign is_empty   = (tx_level == '0);
  assign went_empty = is_empty && !empty_q;
  assign enabled    = fifo_on && tx_irq_en;
  assign fire_free  = first_free && is_empty && enabled;
  assign fire_now   = went_empty && pair_seen;
  assign cancel     = tx_push || !is_empty;
  assign fire_late  = (dly == DLY_W'(1)) && bit_tick && !cancel;
  assign frame_len  = DLY_W'(5) + DLY_W'(char_bits) + DLY_W'(parity_on)
                    + (two_stop ? DLY_W'(2) : DLY_W'(1));

  assign tx_empty_irq = pend && enabled;
  assign tx_reported  = tx_empty_irq && !src_line && !src_rxdata && !src_rxtimeout;
  assign clr          = tx_push || (id_read && tx_reported);

  always_comb begin
    if (src_line)           irq_id = 4'h6;
    else if (src_rxdata)    irq_id = 4'h4;
    else if (src_rxtimeout) irq_id = 4'hC;
    else if (tx_empty_irq)  irq_id = 4'h2;
    else if (src_modem)     irq_id = 4'h0;
    else                    irq_id = 4'h1;
  end
  assign irq_any = !irq_id[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q    <= 1'b1;
      fifo_on_q  <= 1'b0;
      pair_seen  <= 1'b0;
      first_free <= 1'b0;
      pend       <= 1'b0;
      dly        <= '0;
    end else begin
      empty_q   <= is_empty;
      fifo_on_q <= fifo_on;

      if (fifo_on != fifo_on_q) first_free <= 1'b1;
      else if (fire_free)       first_free <= 1'b0;

      if (fire_now || fire_free || fire_late) pair_seen <= 1'b0;
      else if (tx_level >= LVL_W'(2))         pair_seen <= 1'b1;

      if (cancel || fire_free || fire_now || (fifo_on != fifo_on_q))
        dly <= '0;
      else if (went_empty)
        dly <= frame_len;
      else if (bit_tick && dly != '0)
        dly <= dly - DLY_W'(1);

      if (clr)                                pend <= 1'b0;
      else if (fire_now || fire_free || fire_late) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_thre_irq_chk.sv
module uart_thre_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_on,
  input logic       tx_irq_en,
  input logic       tx_push,
  input logic       id_read,
  input logic       src_line,
  input logic       src_rxdata,
  input logic       src_rxtimeout,
  input logic       tx_empty_irq,
  input logic [3:0] irq_id
);
  a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_on && tx_irq_en) |-> !tx_empty_irq);
  a_r6_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_empty_irq);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (id_read && irq_id == 4'h2 && !tx_push) |=> !tx_empty_irq);
  a_r9_line_top: assert property (@(posedge clk) disable iff (!rst_n)
    src_line |-> irq_id == 4'h6);
  a_r9_tx_code: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty_irq && !src_line && !src_rxdata && !src_rxtimeout) |-> irq_id == 4'h2);
endmodule

bind uart_thre_irq uart_thre_irq_chk chk (
  .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .tx_irq_en(tx_irq_en),
  .tx_push(tx_push), .id_read(id_read), .src_line(src_line),
  .src_rxdata(src_rxdata), .src_rxtimeout(src_rxtimeout),
  .tx_empty_irq(tx_empty_irq), .irq_id(irq_id)
);

// File: tb/tb_uart_thre_irq.sv
module tb_uart_thre_irq;
  logic clk = 0, rst_n = 0;
  logic fifo_on = 0, tx_irq_en = 0, tx_push = 0, id_read = 0, bit_tick = 0;
  logic [4:0] tx_level = 0;
  logic [1:0] char_bits = 2'd3;
  logic parity_on = 0, two_stop = 0;
  logic src_line = 0, src_rxdata = 0, src_rxtimeout = 0, src_modem = 0;
  logic tx_empty_irq, irq_any;
  logic [3:0] irq_id;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  uart_thre_irq dut (.*);

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; step(1); bit_tick = 0; step(1);
    end
  endtask

  task automatic push(logic [4:0] lvl);
    tx_push = 1; tx_level = lvl; step(1); tx_push = 0;
  endtask

  task automatic t_reset;
    step(3); rst_n = 1; step(1);
    chk("R10 reset flag", {3'b0, tx_empty_irq}, 4'h0);
    chk("R10 reset id", irq_id, 4'h1);
    chk("R10 reset any", {3'b0, irq_any}, 4'h0);
  endtask

  task automatic t_first_free;
    fifo_on = 1; tx_irq_en = 1; step(1);
    chk("R5 not yet", {3'b0, tx_empty_irq}, 4'h0);
    step(1);
    chk("R5 immediate", {3'b0, tx_empty_irq}, 4'h1);
    chk("R9 tx code", irq_id, 4'h2);
  endtask

  task automatic t_push_clear;
    push(5'd1);
    chk("R6 push clears", {3'b0, tx_empty_irq}, 4'h0);
  endtask

  task automatic t_delay9;
    char_bits = 2'd3; parity_on = 0; two_stop = 0;
    tx_level = 0; step(1);
    ticks(8);
    chk("R3 before 9th tick", {3'b0, tx_empty_irq}, 4'h0);
    ticks(1);
    chk("R3 after 9th tick", {3'b0, tx_empty_irq}, 4'h1);
  endtask

  task automatic t_read_clear;
    src_line = 1; step(0);
    chk("R9 line top", irq_id, 4'h6);
    id_read = 1; step(1); id_read = 0; src_line = 0; step(0);
    chk("R7 masked read keeps", {3'b0, tx_empty_irq}, 4'h1);
    id_read = 1; step(1); id_read = 0;
    chk("R7 read clears", {3'b0, tx_empty_irq}, 4'h0);
    chk("R10 idle id", irq_id, 4'h1);
  endtask

  task automatic t_pair;
    push(5'd1); push(5'd2); tx_level = 1; step(1);
    tx_level = 0; step(1);
    chk("R2 R8 immediate rearm", {3'b0, tx_empty_irq}, 4'h1);
  endtask

  task automatic t_cancel;
    push(5'd1); tx_level = 0; step(1);
    ticks(3);
    push(5'd1);
    ticks(12);
    chk("R4 cancelled", {3'b0, tx_empty_irq}, 4'h0);
    char_bits = 2'd0; parity_on = 1; two_stop = 1;
    tx_level = 0; step(1);
    ticks(7);
    chk("R3 before 8th tick", {3'b0, tx_empty_irq}, 4'h0);
    ticks(1);
    chk("R3 after 8th tick", {3'b0, tx_empty_irq}, 4'h1);
  endtask

  task automatic t_gate;
    tx_irq_en = 0; step(1);
    chk("R1 ier off", {3'b0, tx_empty_irq}, 4'h0);
    chk("R1 id when masked", irq_id, 4'h1);
    tx_irq_en = 1; step(1);
    chk("R1 unmasked", {3'b0, tx_empty_irq}, 4'h1);
  endtask

  task automatic t_prio;
    src_rxdata = 1; src_rxtimeout = 1; step(0);
    chk("R9 data over timeout", irq_id, 4'h4);
    src_rxdata = 0; step(0);
    chk("R9 timeout", irq_id, 4'hC);
    src_rxtimeout = 0; src_modem = 1; step(0);
    chk("R9 tx over modem", irq_id, 4'h2);
    push(5'd1);
    chk("R9 modem", irq_id, 4'h0);
    chk("R10 any", {3'b0, irq_any}, 4'h1);
    src_modem = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset; t_first_free; t_push_clear; t_delay9; t_read_clear;
    t_pair; t_cancel; t_gate; t_prio;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule